// File: doc/BRIEF.md
# Message Controller Interrupt Identifier Arbiter

This block combines the interrupt sources of a message-based bus controller into one identifier register and one interrupt line to the host. There are two kinds of source. The first is a core status-update event that is qualified as error-type or normal. The second is one pending flag for each of 32 message objects. The identifier names the single source that should be serviced first. The line tells the host that something is waiting.

The status source has a reserved identifier and always wins. Otherwise the lowest-numbered pending object is reported, and zero means idle. The host masks the line with its global enable bit. The identifier keeps tracking the sources while the line is masked.

A host read of the status register retires the status interrupt. A host write to the status register does not affect it. Object flags are raised and cleared through per-object strobes.

Top module: `mc_irq_arbiter`

## Requirements
- R1: After reset, and whenever no source is pending, `irq_id` is 0 and `irq_line` is 0.
- R2: A pending status interrupt makes `irq_id` equal 16'h8000, whatever object flags are pending.
- R3: With no status interrupt pending, `irq_id` holds the number of the lowest-numbered pending object. Bit i of the strobe vectors belongs to object i+1, so objects are numbered 1 to 32.
- R4: `irq_line` is 1 exactly when `irq_id` is nonzero and `glb_ie` was 1 at the same sampling edge.
- R5: `irq_id` keeps following the sources while `glb_ie` is 0.
- R6: A `stat_upd` strobe sets the status interrupt only if its enable is 1. The enable is `err_ie` when `stat_err` is 1 (error-type update) and `stat_ie` when `stat_err` is 0. A gated update leaves the state unchanged.
- R7: `host_stat_wr` neither sets nor clears the status interrupt.
- R8: `host_stat_rd` clears the status interrupt. If a `stat_upd` that passes its enable arrives in the same cycle, the interrupt stays pending.
- R9: A strobe on `obj_clr` moves `irq_id` to the next pending object, or to 0 if no object is pending. If `obj_set` and `obj_clr` strobe the same object in one cycle, the flag ends up set.
- R10: `irq_id` and `irq_line` are registered. They show the effect of an input at the same rising edge that samples it. The asynchronous reset drives both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| obj_set | input | 32 | Per-object strobes that raise the pending flags (bit i is object i+1) |
| obj_clr | input | 32 | Per-object strobes that clear the pending flags |
| stat_upd | input | 1 | Strobe: the core updated the status register |
| stat_err | input | 1 | Qualifier for `stat_upd`: 1 for an error-type update, 0 for a normal one |
| glb_ie | input | 1 | Global enable for the interrupt line |
| err_ie | input | 1 | Enable for error-type status interrupts |
| stat_ie | input | 1 | Enable for normal status interrupts |
| host_stat_rd | input | 1 | Host read of the status register |
| host_stat_wr | input | 1 | Host write of the status register |
| irq_id | output | 16 | Identifier of the highest-priority pending source |
| irq_line | output | 1 | Interrupt request to the host |

## Verification
The assertions assume the following:
- The status strobe, host strobes and object strobes are only driven once the internal reset has been released.
- Host read and write strobes are not combined in the checked write-only case.

The stimulus holds every input steady for a whole clock period and changes it only on the falling edge. After any reset it waits several cycles before the first strobe. Each vector puts the two strobe vectors and the status strobe together deliberately, so that races are created on purpose: an update against a read, and a set against a clear.

// File: rtl/mc_irq_pkg.sv
package mc_irq_pkg;
  localparam int unsigned ID_W = 16;
  localparam logic [ID_W-1:0] STATUS_ID = 16'h8000;
  localparam logic [ID_W-1:0] IDLE_ID = '0;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_OBJ  = 2'd1,
    SRC_STAT = 2'd2
  } src_kind_e;
endpackage

// File: rtl/mc_irq_pend_bank.sv
module mc_irq_pend_bank #(
  parameter int unsigned NUM_OBJ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] set_i,
  input  logic [NUM_OBJ-1:0] clr_i,
  output logic [NUM_OBJ-1:0] pend_nxt_o
);
  logic [NUM_OBJ-1:0] pend_q;

  genvar g;
  generate
    for (g = 0; g < NUM_OBJ; g++) begin : g_flag
      // set has priority over a simultaneous clear
      always_comb begin
        pend_nxt_o[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_nxt_o;
    end
  end
endmodule

// File: rtl/mc_irq_status_src.sv
module mc_irq_status_src (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic err_i,
  input  logic err_ie_i,
  input  logic stat_ie_i,
  input  logic rd_i,
  output logic pend_nxt_o
);
  logic pend_q;
  logic upd_ok;

  always_comb begin
    upd_ok     = upd_i & (err_i ? err_ie_i : stat_ie_i);
    // a qualifying update outranks a same-cycle read
    pend_nxt_o = upd_ok | (pend_q & ~rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_nxt_o;
    end
  end
endmodule

// File: rtl/mc_irq_prio_enc.sv
module mc_irq_prio_enc #(
  parameter int unsigned NUM_OBJ = 32,
  localparam int unsigned NUM_W = $clog2(NUM_OBJ + 1)
) (
  input  logic [NUM_OBJ-1:0] pend_i,
  output logic               found_o,
  output logic [NUM_W-1:0]   num_o
);
  always_comb begin
    found_o = |pend_i;
    num_o   = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        num_o = NUM_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/mc_irq_arbiter.sv
module mc_irq_arbiter
  import mc_irq_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] obj_set,
  input  logic [NUM_OBJ-1:0] obj_clr,
  input  logic               stat_upd,
  input  logic               stat_err,
  input  logic               glb_ie,
  input  logic               err_ie,
  input  logic               stat_ie,
  input  logic               host_stat_rd,
  input  logic               host_stat_wr,
  output logic [ID_W-1:0]    irq_id,
  output logic               irq_line
);
  localparam int unsigned NUM_W = $clog2(NUM_OBJ + 1);

  logic [1:0]         rst_sync_q;
  logic               rst_q_n;
  logic [NUM_OBJ-1:0] obj_pend_nxt;
  logic               stat_pend_nxt;
  logic               obj_found;
  logic [NUM_W-1:0]   obj_num;
  src_kind_e          src_sel;
  logic [ID_W-1:0]    id_nxt;
  logic               line_nxt;
  logic               wr_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  // status-register writes are accepted but never touch interrupt state
  assign wr_unused = host_stat_wr;

  mc_irq_pend_bank #(.NUM_OBJ(NUM_OBJ)) u_bank (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .set_i      (obj_set),
    .clr_i      (obj_clr),
    .pend_nxt_o (obj_pend_nxt)
  );

  mc_irq_status_src u_stat (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .upd_i      (stat_upd),
    .err_i      (stat_err),
    .err_ie_i   (err_ie),
    .stat_ie_i  (stat_ie),
    .rd_i       (host_stat_rd),
    .pend_nxt_o (stat_pend_nxt)
  );

  mc_irq_prio_enc #(.NUM_OBJ(NUM_OBJ)) u_enc (
    .pend_i  (obj_pend_nxt),
    .found_o (obj_found),
    .num_o   (obj_num)
  );

  always_comb begin
    if (stat_pend_nxt)  src_sel = SRC_STAT;
    else if (obj_found) src_sel = SRC_OBJ;
    else                src_sel = SRC_NONE;
    case (src_sel)
      SRC_STAT: id_nxt = STATUS_ID;
      SRC_OBJ:  id_nxt = ID_W'(obj_num);
      default:  id_nxt = IDLE_ID;
    endcase
    line_nxt = glb_ie & (src_sel != SRC_NONE);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      irq_id   <= IDLE_ID;
      irq_line <= 1'b0;
    end else begin
      irq_id   <= id_nxt;
      irq_line <= line_nxt;
    end
  end
endmodule

// File: rtl/mc_irq_arbiter_chk.sv
module mc_irq_arbiter_chk #(
  parameter int unsigned NUM_OBJ = 32
) (
  input logic        clk,
  input logic        rst_q_n,
  input logic        stat_upd,
  input logic        stat_err,
  input logic        err_ie,
  input logic        stat_ie,
  input logic        glb_ie,
  input logic        host_stat_rd,
  input logic        host_stat_wr,
  input logic [15:0] irq_id,
  input logic        irq_line
);
  // R4
  line_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_line |-> (irq_id != 16'h0));

  // R4
  line_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_line |-> $past(glb_ie));

  // R3
  id_legal_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_id == 16'h0) || (irq_id == 16'h8000) ||
    ((irq_id >= 16'd1) && (irq_id <= 16'(NUM_OBJ))));

  // R7
  wr_keeps_stat_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (host_stat_wr && !host_stat_rd && !stat_upd && irq_id == 16'h8000)
      |=> (irq_id == 16'h8000));

  // R2
  stat_wins_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stat_upd && ((stat_err && err_ie) || (!stat_err && stat_ie)))
      |=> (irq_id == 16'h8000));

  // R8
  rd_clears_stat_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (host_stat_rd && !stat_upd) |=> (irq_id != 16'h8000));
endmodule

bind mc_irq_arbiter mc_irq_arbiter_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .stat_upd     (stat_upd),
  .stat_err     (stat_err),
  .err_ie       (err_ie),
  .stat_ie      (stat_ie),
  .glb_ie       (glb_ie),
  .host_stat_rd (host_stat_rd),
  .host_stat_wr (host_stat_wr),
  .irq_id       (irq_id),
  .irq_line     (irq_line)
);

// File: tb/mc_irq_arbiter_test.sv
module mc_irq_arbiter_test;
  localparam int VW = 88;
  localparam int NV = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] obj_set = '0;
  logic [31:0] obj_clr = '0;
  logic        stat_upd = 1'b0, stat_err = 1'b0, glb_ie = 1'b0;
  logic        err_ie = 1'b0, stat_ie = 1'b0;
  logic        host_stat_rd = 1'b0, host_stat_wr = 1'b0;
  logic [15:0] irq_id;
  logic        irq_line;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  mc_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .obj_set(obj_set), .obj_clr(obj_clr),
    .stat_upd(stat_upd), .stat_err(stat_err), .glb_ie(glb_ie),
    .err_ie(err_ie), .stat_ie(stat_ie), .host_stat_rd(host_stat_rd),
    .host_stat_wr(host_stat_wr), .irq_id(irq_id), .irq_line(irq_line)
  );

  // {set, clr, upd, err, ie, eie, sie, rd, wr, exp_id, exp_line}
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 7'b0010000, 16'h0000, 1'b0}, // R1 idle
    {32'h0000_0010, 32'h0000_0000, 7'b0010000, 16'h0005, 1'b1}, // R3 obj5
    {32'h0000_0004, 32'h0000_0000, 7'b0010000, 16'h0003, 1'b1}, // R3 obj3 wins
    {32'h8000_0000, 32'h0000_0000, 7'b0010000, 16'h0003, 1'b1}, // R3 obj32 lower prio
    {32'h0000_0000, 32'h0000_0000, 7'b0000000, 16'h0003, 1'b0}, // R4 masked
    {32'h0000_0000, 32'h0000_0004, 7'b0000000, 16'h0005, 1'b0}, // R5 moves while masked
    {32'h0000_0000, 32'h0000_0000, 7'b0010000, 16'h0005, 1'b1}, // R4 unmask
    {32'h0000_0000, 32'h0000_0000, 7'b1010100, 16'h8000, 1'b1}, // R2 normal upd
    {32'h0000_0000, 32'h0000_0000, 7'b0010001, 16'h8000, 1'b1}, // R7 write no clear
    {32'h0000_0000, 32'h0000_0000, 7'b0010010, 16'h0005, 1'b1}, // R8 read clears
    {32'h0000_0000, 32'h0000_0000, 7'b1110100, 16'h0005, 1'b1}, // R6 err gated
    {32'h0000_0000, 32'h0000_0000, 7'b1111000, 16'h8000, 1'b1}, // R6 err enabled
    {32'h0000_0000, 32'h0000_0000, 7'b1010110, 16'h8000, 1'b1}, // R8 upd beats read
    {32'h0000_0000, 32'h0000_0000, 7'b0010010, 16'h0005, 1'b1}, // R8 read clears
    {32'h0000_0000, 32'h0000_0010, 7'b0010000, 16'h0020, 1'b1}, // R9 next obj32
    {32'h0000_0001, 32'h0000_0001, 7'b0010000, 16'h0001, 1'b1}, // R9 set beats clr
    {32'h0000_0000, 32'h0000_0001, 7'b0010000, 16'h0020, 1'b1}, // R9 clr obj1
    {32'h0000_0000, 32'h8000_0000, 7'b0010000, 16'h0000, 1'b0}, // R9 to zero
    {32'h0000_0000, 32'h0000_0000, 7'b1011000, 16'h0000, 1'b0}, // R6 normal gated
    {32'h0000_0000, 32'h0000_0000, 7'b0010001, 16'h0000, 1'b0}, // R7 write no raise
    {32'h0000_0000, 32'h0000_0000, 7'b0011100, 16'h0000, 1'b0}  // R1 enables only
  };

  task automatic check(input string req, input logic [15:0] exp_id,
                       input logic exp_line);
    total++;
    if (irq_id !== exp_id || irq_line !== exp_line) begin
      bad++;
      $display("FAIL %s: id=%h line=%b expected id=%h line=%b",
               req, irq_id, irq_line, exp_id, exp_line);
    end
  endtask

  task automatic idle_inputs();
    obj_set = '0; obj_clr = '0; stat_upd = 0; stat_err = 0;
    host_stat_rd = 0; host_stat_wr = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 during reset", 16'h0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 16'h0, 1'b0);

    // R10: each vector's effect is visible right after the sampling edge
    for (int v = 0; v < NV; v++) begin
      {obj_set, obj_clr, stat_upd, stat_err, glb_ie, err_ie, stat_ie,
       host_stat_rd, host_stat_wr} = VEC[v][VW-1:17];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R10 vector %0d", v), VEC[v][16:1], VEC[v][0]);
    end
    idle_inputs();

    // R10 async reset with sources pending
    obj_set = 32'h0000_0100; stat_upd = 1; stat_ie = 1; glb_ie = 1;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R2 before reset", 16'h8000, 1'b1);
    #3 rst_n = 1'b0;
    #1 check("R10 async reset", 16'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flags cleared by reset", 16'h0, 1'b0);

    // R3 highest object alone
    obj_set = 32'h8000_0000;
    @(posedge clk); @(negedge clk);
    obj_set = '0;
    check("R3 obj32 alone", 16'h0020, 1'b1);
    // R7 write with pending status from err path, then read
    stat_upd = 1; stat_err = 1; err_ie = 1;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    host_stat_wr = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    host_stat_wr = 0;
    check("R7 repeated writes", 16'h8000, 1'b1);
    host_stat_rd = 1;
    @(posedge clk); @(negedge clk);
    host_stat_rd = 0;
    check("R8 read back to object", 16'h0020, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule